// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front End

This block is the bus-side controller of a small serial EEPROM that holds 512 bytes. It only ever acts as a slave. It oversamples the open-drain clock and data lines with the system clock and recognises START and STOP conditions. It then shifts in a select byte, an address byte and data bytes. It pulls the data line low to acknowledge, and it shifts stored bytes back out during reads. Outgoing data is modelled as a single "pull low" enable, so the pad itself stays outside the block.

Incoming write bytes collect in a 16-byte page buffer. The STOP that closes a write with at least one data byte starts a programming window whose length is a parameter. During that window the bus is ignored. When the window ends, the buffered bytes land in the storage array and a one-cycle done pulse is raised. A write-control input limits each write command to a single data byte. A read ends only when the master answers a byte with a NACK and then sends STOP.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes clocked in without a preceding START get no acknowledge.
- R2: The select byte is MSB first and laid out as bits[7:4] = 4'b1010, bits[3:2] = 2'b00, bit1 = address bit 8, and bit0 = direction (1 = read). On a mismatch the slave sends no acknowledge and stays silent until the next START.
- R3: SDA is sampled on SCL rising edges, MSB first. After each received byte that the slave accepts, it holds SDA low for the whole 9th clock.
- R4: The slave changes its SDA drive only after a detected SCL falling edge, or on a START or STOP. It never changes the drive while SCL stays high.
- R5: A write command carrying select bit1 and one address byte sets the 9-bit pointer to {bit1, address}. A repeated START followed by a read select then returns the byte stored there.
- R6: A read returns successive bytes while the master acknowledges each one. The pointer advances after every byte and wraps from 0x1FF to 0x000. A read that starts with no address phase begins at the current pointer.
- R7: A write accepts up to 16 data bytes into the page of the starting address. The low 4 address bits wrap inside that page.
- R8: A STOP after at least one accepted data byte starts a programming window of PROG_CYCLES clocks. During the window the bus gets no response, and no acknowledge is given even to a valid select. At the end, write_done is high for exactly one cycle and the bytes are readable.
- R9: A STOP that follows only a select and an address byte starts no programming, raises no write_done and leaves the pointer at that address.
- R10: While wr_ctrl is high, the first data byte of a write is acknowledged and programmed. A second data byte gets no acknowledge, and the whole command is dropped: no programming and no write_done.
- R11: During a read, a STOP sent after an acknowledged byte is ignored and the transfer continues. After a NACK the slave releases SDA, and the following STOP returns it to idle.
- R12: After reset, sda_oe and write_done are low and every stored byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| wr_ctrl | input | 1 | High limits each write command to one data byte |
| sda_oe | output | 1 | High pulls the data line low |
| write_done | output | 1 | One-cycle pulse when a programming window ends |

## Verification
Some rules are checked by assertions on every cycle. The data drive never moves except after an SCL fall or a bus condition. The drive stays released for the whole programming window. The done pulse lasts a single cycle. The pointer never leaves its page while a write is collecting bytes. Any commit always carries at least one byte. Other behaviour shows up only in the bench's scenarios. These cover the byte values on sequential reads across the array wrap, the page wrap of a four-byte write, the dropped command under write control, and the refused select during programming. They also cover the STOP that a read ignores until a NACK.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int MEM_BYTES  = 512;
    localparam int ADDR_W     = $clog2(MEM_BYTES);
    localparam int PAGE_BYTES = 16;
    localparam int PAGE_W     = $clog2(PAGE_BYTES);
    localparam int BASE_W     = ADDR_W - PAGE_W;

    typedef logic [7:0]        byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BASE_W-1:0] base_t;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SEL,
        PH_ADR,
        PH_WDAT,
        PH_ACK,
        PH_TX,
        PH_MACK,
        PH_IGN,
        PH_BUSY
    } phase_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    function automatic logic sel_match(input byte_t b, input logic [3:0] ty,
                                       input logic [1:0] sub);
        return (b[7:4] == ty) && (b[3:2] == sub);
    endfunction

endpackage

// File: rtl/eep_line_sense.sv
module eep_line_sense
    import eep_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [SYNC-1:0] scl_sy;
    logic [SYNC-1:0] sda_sy;
    logic            scl_p;
    logic            sda_p;
    logic            scl_n;
    logic            sda_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[SYNC-2:0], scl_i};
            sda_sy <= {sda_sy[SYNC-2:0], sda_i};
            scl_p  <= scl_sy[SYNC-1];
            sda_p  <= sda_sy[SYNC-1];
        end
    end

    assign scl_n = scl_sy[SYNC-1];
    assign sda_n = sda_sy[SYNC-1];

    always_comb begin
        ev.scl_rise = scl_n & ~scl_p;
        ev.scl_fall = ~scl_n & scl_p;
        // R1: data edges while the clock stays high mark bus conditions
        ev.start    = scl_n & scl_p & sda_p & ~sda_n;
        ev.stop     = scl_n & scl_p & ~sda_p & sda_n;
        ev.sda      = sda_n;
    end

endmodule

// File: rtl/eep_array.sv
module eep_array
    import eep_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  addr_t                        rd_addr,
    output byte_t                        rd_data,
    input  logic                         commit,
    input  base_t                        page_base,
    input  logic [PAGE_BYTES-1:0]        page_mask,
    input  logic [PAGE_BYTES-1:0][7:0]   page_data
);
    byte_t mem [MEM_BYTES];

    for (genvar j = 0; j < MEM_BYTES; j++) begin : g_cell
        localparam int LANE = j % PAGE_BYTES;
        localparam int BASE = j / PAGE_BYTES;
        always_ff @(posedge clk) begin
            if (rst)
                mem[j] <= '0;
            else if (commit && page_base == BASE_W'(BASE) && page_mask[LANE])
                mem[j] <= page_data[LANE];
        end
    end

    assign rd_data = mem[rd_addr];

    // R8
    commit_mask_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> (page_mask != '0));

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import eep_pkg::*;
#(
    parameter int         PROG_CYCLES = 1000,
    parameter logic [3:0] DEV_TYPE    = 4'b1010,
    parameter logic [1:0] DEV_SUB     = 2'b00
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wr_ctrl,
    output logic sda_oe,
    output logic write_done
);
    localparam int BW = $clog2(PROG_CYCLES + 1);

    line_ev_t                     ev;
    phase_t                       ph;
    phase_t                       after_ph;
    logic [3:0]                   bit_cnt;
    byte_t                        rx_sh;
    byte_t                        tx_sh;
    addr_t                        ptr;
    logic                         a8;
    logic [PAGE_BYTES-1:0][7:0]   pbuf;
    logic [PAGE_BYTES-1:0]        pmask;
    logic                         mack_ok;
    logic [BW-1:0]                busy_cnt;
    logic                         commit;
    byte_t                        rd_data;
    logic [PAGE_W-1:0]            lane;

    eep_line_sense #(.SYNC(2)) u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    eep_array u_array (
        .clk       (clk),
        .rst       (rst),
        .rd_addr   (ptr),
        .rd_data   (rd_data),
        .commit    (commit),
        .page_base (ptr[ADDR_W-1:PAGE_W]),
        .page_mask (pmask),
        .page_data (pbuf)
    );

    assign lane   = ptr[PAGE_W-1:0];
    // R8: the programming window closes by committing the buffered page
    assign commit = (ph == PH_BUSY) && (busy_cnt == BW'(PROG_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            after_ph   <= PH_IDLE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            ptr        <= '0;
            a8         <= 1'b0;
            pbuf       <= '0;
            pmask      <= '0;
            mack_ok    <= 1'b0;
            busy_cnt   <= '0;
            sda_oe     <= 1'b0;
            write_done <= 1'b0;
        end else begin
            write_done <= 1'b0;
            if (ph == PH_BUSY) begin
                // R8: bus fully ignored while programming
                if (commit) begin
                    ph         <= PH_IDLE;
                    busy_cnt   <= '0;
                    write_done <= 1'b1;
                end else begin
                    busy_cnt <= busy_cnt + BW'(1);
                end
            end else if (ev.start) begin
                ph      <= PH_SEL;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                case (ph)
                    // R11: a read only ends after a NACK
                    PH_TX, PH_MACK: ;
                    PH_WDAT: begin
                        sda_oe   <= 1'b0;
                        busy_cnt <= '0;
                        // R9: nothing to program without data bytes
                        ph       <= (pmask != '0) ? PH_BUSY : PH_IDLE;
                    end
                    default: begin
                        sda_oe <= 1'b0;
                        ph     <= PH_IDLE;
                    end
                endcase
            end else begin
                case (ph)
                    PH_SEL, PH_ADR, PH_WDAT: begin
                        if (ev.scl_rise) begin
                            // R3: MSB first, sampled on the rising edge
                            rx_sh   <= {rx_sh[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (ph == PH_SEL) begin
                                // R2: select match decides acknowledge
                                if (sel_match(rx_sh, DEV_TYPE, DEV_SUB)) begin
                                    sda_oe <= 1'b1;
                                    ph     <= PH_ACK;
                                    if (rx_sh[0]) begin
                                        after_ph <= PH_TX;
                                    end else begin
                                        after_ph <= PH_ADR;
                                        a8       <= rx_sh[1];
                                    end
                                end else begin
                                    ph <= PH_IGN;
                                end
                            end else if (ph == PH_ADR) begin
                                // R5: pointer from select bit and address byte
                                sda_oe   <= 1'b1;
                                ph       <= PH_ACK;
                                after_ph <= PH_WDAT;
                                ptr      <= {a8, rx_sh};
                                pmask    <= '0;
                            end else if (wr_ctrl && pmask != '0) begin
                                // R10: multibyte write refused and dropped
                                ph    <= PH_IGN;
                                pmask <= '0;
                            end else begin
                                // R7: wrap inside the page
                                sda_oe            <= 1'b1;
                                ph                <= PH_ACK;
                                after_ph          <= PH_WDAT;
                                pbuf[lane]        <= rx_sh;
                                pmask[lane]       <= 1'b1;
                                ptr[PAGE_W-1:0]   <= lane + PAGE_W'(1);
                            end
                        end
                    end
                    PH_ACK: begin
                        if (ev.scl_fall) begin
                            ph      <= after_ph;
                            bit_cnt <= '0;
                            if (after_ph == PH_TX) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe  <= 1'b0;
                                ph      <= PH_MACK;
                                bit_cnt <= '0;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                            end
                        end
                    end
                    PH_MACK: begin
                        if (ev.scl_rise) begin
                            mack_ok <= ~ev.sda;
                            // R6: advance with wrap at the array end
                            ptr     <= ptr + ADDR_W'(1);
                        end else if (ev.scl_fall) begin
                            if (mack_ok) begin
                                ph     <= PH_TX;
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                ph <= PH_IGN;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4
    oe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(ev.scl_fall || ev.start || ev.stop));

    // R8
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_BUSY) |-> !sda_oe);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        write_done |=> !write_done);

    // R8
    busy_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy_cnt < BW'(PROG_CYCLES));

    // R7
    page_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ACK && $past(ph) == PH_WDAT) |->
            ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

endmodule

// File: tb/sim_serial_eeprom_slave.sv
module sim_serial_eeprom_slave;
    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 300;
    localparam int H          = 5;
    localparam int NV         = 6;
    localparam logic [16:0] VEC [0:NV-1] = '{
        {9'h000, 8'h5A}, {9'h0FF, 8'h3C}, {9'h100, 8'hA7},
        {9'h1A3, 8'h11}, {9'h1A4, 8'hC5}, {9'h1FF, 8'hE1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wr_ctrl = 1'b0;
    logic sda_oe;
    logic write_done;
    logic sda_bus;
    int   n_chk = 0;
    int   n_err = 0;
    int   done_cnt = 0;
    int   run = 0;
    int   max_run = 0;
    int   hi_moves = 0;
    logic oe_q = 1'b0;
    logic scl_q = 1'b1;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_eeprom_slave #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
        .wr_ctrl(wr_ctrl), .sda_oe(sda_oe), .write_done(write_done)
    );

    always @(posedge clk) begin
        if (write_done) begin
            done_cnt <= done_cnt + 1;
            run      <= run + 1;
            if (run + 1 > max_run) max_run <= run + 1;
        end else begin
            run <= 0;
        end
        if (!rst && scl && scl_q && sda_oe != oe_q) hi_moves <= hi_moves + 1;
        oe_q  <= sda_oe;
        scl_q <= scl;
    end

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic s);
        scl = 1'b0; tick(H);
        sda_m = b;  tick(H);
        scl = 1'b1; tick(H);
        s = sda_bus; tick(H);
    endtask

    task automatic start_c();
        scl = 1'b0; tick(H);
        sda_m = 1'b1; tick(H);
        scl = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
    endtask

    task automatic stop_c();
        scl = 1'b0; tick(H);
        sda_m = 1'b0; tick(H);
        scl = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_bits(input int n, output logic [7:0] v);
        logic s;
        v = '0;
        for (int i = 0; i < n; i++) begin
            bit_io(1'b1, s);
            v = {v[6:0], s};
        end
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic s;
        recv_bits(8, d);
        bit_io(nack, s);
    endtask

    function automatic logic [7:0] sel(input logic a8, input logic rd);
        return {4'b1010, 2'b00, a8, rd};
    endfunction

    task automatic set_addr(input logic [8:0] a, output int acks);
        logic k;
        acks = 0;
        start_c();
        send_byte(sel(a[8], 1'b0), k); acks += int'(k);
        send_byte(a[7:0], k);          acks += int'(k);
    endtask

    task automatic read_at(input logic [8:0] a, input int n, output logic [7:0] d [4]);
        int   acks;
        logic k;
        set_addr(a, acks);
        start_c();
        send_byte(sel(1'b0, 1'b1), k);
        for (int i = 0; i < n; i++) recv_byte(i == n - 1, d[i]);
        stop_c();
    endtask

    task automatic wait_done(output bit seen, output int lat);
        int c0;
        c0 = done_cnt;
        seen = 1'b0;
        lat = 0;
        for (int i = 0; i < PROG + 60; i++) begin
            tick(1);
            if (!seen) lat++;
            if (done_cnt != c0) seen = 1'b1;
        end
    endtask

    initial begin
        logic [7:0] d [4];
        logic [7:0] v;
        logic       k;
        logic       s;
        int         acks;
        int         lat;
        bit         seen;

        tick(5);
        rst = 1'b0;
        tick(3);

        // R12: reset state
        chk(sda_oe == 1'b0, "R12 sda_oe after reset", sda_oe, 0);
        chk(write_done == 1'b0, "R12 write_done after reset", write_done, 0);
        read_at(9'h123, 1, d);
        chk(d[0] == 8'h00, "R12 array cleared", d[0], 0);

        // Table: single-byte writes then random reads (R5, R3, R8)
        for (int i = 0; i < NV; i++) begin
            set_addr(VEC[i][16:8], acks);
            send_byte(VEC[i][7:0], k);
            chk(acks == 2 && k, "R3 write acknowledges", acks + int'(k), 3);
            stop_c();
            wait_done(seen, lat);
            chk(seen, "R8 write_done after write", int'(seen), 1);
            read_at(VEC[i][16:8], 1, d);
            chk(d[0] == VEC[i][7:0], "R5 random read value", d[0], VEC[i][7:0]);
        end
        chk(max_run == 1, "R8 write_done width", max_run, 1);

        // R1: no START, no acknowledge
        tick(20);
        send_byte(8'hA0, k);
        chk(!k, "R1 byte without START", int'(k), 0);
        stop_c();

        // R2: wrong type and wrong sub code
        start_c(); send_byte(8'hB0, k); stop_c();
        chk(!k, "R2 type mismatch", int'(k), 0);
        start_c(); send_byte(8'hA4, k); stop_c();
        chk(!k, "R2 sub code mismatch", int'(k), 0);

        // R6: sequential read across array end
        read_at(9'h1FF, 2, d);
        chk(d[0] == 8'hE1 && d[1] == 8'h5A, "R6 wrap 1FF to 000", {d[0], d[1]}, 16'hE15A);

        // R7 + R8: four-byte page write wrapping in page, busy ignores bus
        set_addr(9'h1FE, acks);
        send_byte(8'hD0, k); send_byte(8'hD1, k); send_byte(8'hD2, k); send_byte(8'hD3, k);
        chk(k, "R7 fourth page byte acknowledged", int'(k), 1);
        stop_c();
        start_c();
        send_byte(sel(1'b0, 1'b1), k);
        chk(!k, "R8 no response while programming", int'(k), 0);
        stop_c();
        wait_done(seen, lat);
        chk(seen, "R8 write_done after page", int'(seen), 1);
        set_addr(9'h0FE, acks);
        stop_c();
        set_addr(9'h1FE, acks);
        stop_c();
        wait_done(seen, lat);
        chk(!seen, "R9 address-only no program", int'(seen), 0);
        start_c();
        send_byte(sel(1'b0, 1'b1), k);
        recv_byte(1'b0, d[0]);
        recv_byte(1'b0, d[1]);
        recv_byte(1'b1, d[2]);
        stop_c();
        chk(d[0] == 8'hD0 && d[1] == 8'hD1, "R9 current read from set pointer", {d[0], d[1]}, 16'hD0D1);
        chk(d[2] == 8'h5A, "R6 sequential wrap to 000", d[2], 8'h5A);
        read_at(9'h1F0, 2, d);
        chk(d[0] == 8'hD2 && d[1] == 8'hD3, "R7 page wrap bytes", {d[0], d[1]}, 16'hD2D3);

        // R8: window length
        set_addr(9'h020, acks);
        send_byte(8'h66, k);
        stop_c();
        wait_done(seen, lat);
        chk(seen && lat >= PROG - 8 && lat <= PROG + 2, "R8 window length", lat, PROG);

        // R10: write control
        wr_ctrl = 1'b1;
        set_addr(9'h050, acks);
        send_byte(8'h77, k);
        chk(k, "R10 single byte acknowledged", int'(k), 1);
        stop_c();
        wait_done(seen, lat);
        chk(seen, "R10 single byte programmed", int'(seen), 1);
        set_addr(9'h060, acks);
        send_byte(8'h12, k);
        send_byte(8'h34, k);
        chk(!k, "R10 second byte refused", int'(k), 0);
        stop_c();
        wait_done(seen, lat);
        chk(!seen, "R10 dropped command no program", int'(seen), 0);
        wr_ctrl = 1'b0;
        read_at(9'h050, 1, d);
        chk(d[0] == 8'h77, "R10 single byte readback", d[0], 8'h77);
        read_at(9'h060, 1, d);
        chk(d[0] == 8'h00, "R10 dropped byte absent", d[0], 0);

        // R11: STOP ignored before NACK
        set_addr(9'h1A3, acks);
        start_c();
        send_byte(sel(1'b1, 1'b1), k);
        recv_bits(8, v);
        bit_io(1'b0, s);
        chk(v == 8'h11, "R11 first read byte", v, 8'h11);
        stop_c();
        recv_bits(7, v);
        bit_io(1'b1, s);
        chk(v[6:0] == 7'h45, "R11 read continues past STOP", v[6:0], 7'h45);
        stop_c();
        read_at(9'h0FF, 1, d);
        chk(d[0] == 8'h3C, "R11 idle after NACK and STOP", d[0], 8'h3C);

        // R4: drive never moved with SCL high
        chk(hi_moves == 0, "R4 drive stable while SCL high", hi_moves, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired got 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule